// File: doc/BRIEF.md
# Quadrature Phase Decoder Front End

This block sits between an incremental encoder and a position counter. It takes the two phase inputs and the index input from outside the chip and brings each of them onto the system clock with a synchroniser. It then turns phase activity into single-cycle up and down count strobes for a counter that lives elsewhere. In quadrature mode the phases pass through a glitch filter first. The decoder then counts at one of three resolutions: every phase edge, every edge of phase A, or one edge per full electrical cycle. It also flags illegal transitions, where both phases move in the same sample, as noise.

In clock/direction mode the filter and the decoder are bypassed. Each rising edge of phase A is one count, and phase B gives the direction. The block also qualifies the index input for the counter. In direct mode the index is active low and is reported as a level. In synchronous mode the index is reported only together with a count strobe, at a selectable polarity.

The count strobes are plain one-cycle pulses with no handshake. The counter must take a strobe in the cycle it appears. Back-pressure is not possible, because the encoder cannot be stalled.

Top module: `qdec_front`

## Requirements
- R1: After reset `cnt_up_o`, `cnt_dn_o`, `noise_err_o` and `index_hit_o` are 0, and `dir_o` is 1.
- R2: With `quad_mode_i`=1 and `res_sel_i`=2 (x4), every accepted change of exactly one phase gives one strobe. Gray order (A,B) 00, 10, 11, 01, 00 counts up, and the reverse order counts down.
- R3: `res_sel_i` encoding: 0 selects x1, 1 selects x2, 2 selects x4, and 3 behaves as x4. In x2 only changes of A count. In x1 only (A,B) 00 to 10 counts (up) and 10 to 00 counts (down).
- R4: In quadrature mode a new level on A or B is accepted only after 3 consecutive equal synchronised samples. A pulse of 2 cycles gives no strobe.
- R5: In quadrature mode, a sample in which A and B both change gives no strobe and sets `noise_err_o`.
- R6: `noise_err_o` stays set until `err_clr_i` is high on a clock edge. If the flag is being set in that same cycle, the set wins. The flag is never set while `quad_mode_i`=0.
- R7: With `quad_mode_i`=0 the filter is bypassed. Each rising edge of A (a high pulse of 2 cycles is enough) gives one strobe: up when B is 1, down when B is 0. `res_sel_i` is ignored.
- R8: `dir_o` becomes 1 with an up strobe and 0 with a down strobe. It holds its value between strobes.
- R9: In direct index mode `index_hit_o` is the inverse of the synchronised `index_i`, and `idx_pol_i` has no effect.
- R10: With `quad_mode_i`=1 and `sync_idx_i`=1, `index_hit_o` is 1 only in a strobe cycle in which the synchronised index equals `idx_pol_i`. With `quad_mode_i`=0 the index always behaves as in direct mode, whatever `sync_idx_i` is.
- R11: Each strobe lasts one cycle per count, and `cnt_up_o` and `cnt_dn_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| phase_a_i | input | 1 | encoder phase A (asynchronous) |
| phase_b_i | input | 1 | encoder phase B (asynchronous) |
| index_i | input | 1 | encoder index (asynchronous) |
| quad_mode_i | input | 1 | 1 quadrature, 0 clock/direction |
| res_sel_i | input | 2 | resolution: 0 x1, 1 x2, 2 or 3 x4 |
| sync_idx_i | input | 1 | 1 synchronous index qualification |
| idx_pol_i | input | 1 | active index level in synchronous mode |
| err_clr_i | input | 1 | clears the noise flag |
| cnt_up_o | output | 1 | one-cycle up count strobe |
| cnt_dn_o | output | 1 | one-cycle down count strobe |
| dir_o | output | 1 | last count direction, 1 up |
| noise_err_o | output | 1 | sticky illegal-transition flag |
| index_hit_o | output | 1 | qualified index |

## Verification
A corrupted filter level or a corrupted previous-phase register shows at the ports as an extra strobe, a missing strobe or a strobe of the wrong sign. This appears within about six cycles of the phase change that exposes it. The bench compares each strobe against an expected queue, so it catches any of these at once. A wrong noise or direction register shows as soon as the next illegal step, clear or count happens. A wrong index qualification shows in the first strobe cycle after the index level is set.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam logic [1:0] RES_X1 = 2'd0;
  localparam logic [1:0] RES_X2 = 2'd1;
  localparam logic [1:0] RES_X4 = 2'd2;
  localparam int         PHASES = 2;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n) sh <= {STAGES{RST_VAL[g]}};
      else        sh <= {sh[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int WIDTH  = 2,
  parameter int STABLE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CW = $clog2(STABLE + 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_ch
    logic          lvl;
    logic [CW-1:0] run;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl <= 1'b0;
        run <= '0;
      end else if (d_i[g] == lvl) begin
        run <= '0;
      end else if (run == CW'(STABLE - 1)) begin
        lvl <= d_i[g];
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
    assign q_o[g] = lvl;
  end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_i,
  input  logic [1:0] res_i,
  input  logic       flt_a_i,
  input  logic       flt_b_i,
  input  logic       raw_a_i,
  input  logic       raw_b_i,
  input  logic       err_clr_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       dir_o,
  output logic       noise_o
);
  logic pa, pb, pra;
  logic ch_a, ch_b, single, illegal, q_up, q_hit;
  logic hit, up;

  always_comb begin
    ch_a    = flt_a_i ^ pa;
    ch_b    = flt_b_i ^ pb;
    single  = ch_a ^ ch_b;
    illegal = ch_a & ch_b;
    q_up    = flt_a_i ^ pb;
    case (res_i)
      RES_X1:  q_hit = ch_a & ~pb & ~flt_b_i;
      RES_X2:  q_hit = single & ch_a;
      default: q_hit = single;
    endcase
    hit = quad_i ? q_hit : (raw_a_i & ~pra);
    up  = quad_i ? q_up  : raw_b_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa      <= 1'b0;
      pb      <= 1'b0;
      pra     <= 1'b0;
      up_o    <= 1'b0;
      dn_o    <= 1'b0;
      dir_o   <= 1'b1;
      noise_o <= 1'b0;
    end else begin
      pa   <= flt_a_i;
      pb   <= flt_b_i;
      pra  <= raw_a_i;
      up_o <= hit & up;
      dn_o <= hit & ~up;
      if (hit) dir_o <= up;
      if (quad_i && illegal) noise_o <= 1'b1;
      else if (err_clr_i)    noise_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_index.sv
module qdec_index (
  input  logic idx_s_i,
  input  logic quad_i,
  input  logic sync_i,
  input  logic pol_i,
  input  logic strobe_i,
  output logic hit_o
);
  always_comb begin
    if (quad_i && sync_i) hit_o = strobe_i & (idx_s_i == pol_i);
    else                  hit_o = ~idx_s_i;
  end
endmodule

// File: rtl/qdec_front.sv
module qdec_front
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_a_i,
  input  logic       phase_b_i,
  input  logic       index_i,
  input  logic       quad_mode_i,
  input  logic [1:0] res_sel_i,
  input  logic       sync_idx_i,
  input  logic       idx_pol_i,
  input  logic       err_clr_i,
  output logic       cnt_up_o,
  output logic       cnt_dn_o,
  output logic       dir_o,
  output logic       noise_err_o,
  output logic       index_hit_o
);
  localparam int NUM_IN  = PHASES + 1;
  localparam int IDX_BIT = PHASES;

  logic [NUM_IN-1:0] raw_s;
  logic [PHASES-1:0] flt;

  qdec_sync #(
    .WIDTH  (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(NUM_IN'(1) << IDX_BIT)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({index_i, phase_b_i, phase_a_i}),
    .q_o  (raw_s)
  );

  qdec_filter #(
    .WIDTH (PHASES),
    .STABLE(FILT_LEN)
  ) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_s[PHASES-1:0]),
    .q_o  (flt)
  );

  qdec_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .quad_i   (quad_mode_i),
    .res_i    (res_sel_i),
    .flt_a_i  (flt[0]),
    .flt_b_i  (flt[1]),
    .raw_a_i  (raw_s[0]),
    .raw_b_i  (raw_s[1]),
    .err_clr_i(err_clr_i),
    .up_o     (cnt_up_o),
    .dn_o     (cnt_dn_o),
    .dir_o    (dir_o),
    .noise_o  (noise_err_o)
  );

  qdec_index u_idx (
    .idx_s_i (raw_s[IDX_BIT]),
    .quad_i  (quad_mode_i),
    .sync_i  (sync_idx_i),
    .pol_i   (idx_pol_i),
    .strobe_i(cnt_up_o | cnt_dn_o),
    .hit_o   (index_hit_o)
  );
endmodule

// File: rtl/qdec_front_chk.sv
module qdec_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       quad_mode_i,
  input logic       sync_idx_i,
  input logic       err_clr_i,
  input logic       cnt_up_o,
  input logic       cnt_dn_o,
  input logic       dir_o,
  input logic       noise_err_o,
  input logic       index_hit_o
);
  assert_excl_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up_o && cnt_dn_o));

  assert_dir_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_up_o |-> dir_o);

  assert_dir_dn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dn_o |-> !dir_o);

  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up_o || cnt_dn_o) |-> $stable(dir_o));

  assert_noise_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err_o && !err_clr_i) |=> noise_err_o);

  assert_noise_clr_nq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i && !quad_mode_i) |=> !noise_err_o);

  assert_sync_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_mode_i && sync_idx_i && index_hit_o) |-> (cnt_up_o || cnt_dn_o));
endmodule

bind qdec_front qdec_front_chk u_chk (.*);

// File: tb/qdec_front_tb.sv
module qdec_front_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_a_i = 1'b0, phase_b_i = 1'b0, index_i = 1'b1;
  logic       quad_mode_i = 1'b1, sync_idx_i = 1'b0, idx_pol_i = 1'b0, err_clr_i = 1'b0;
  logic [1:0] res_sel_i = 2'd2;
  logic       cnt_up_o, cnt_dn_o, dir_o, noise_err_o, index_hit_o;

  int checks = 0;
  int fails  = 0;
  int hit_cnt = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  qdec_front u_dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // gray position of (A,B): 00->0, 10->1, 11->2, 01->3
  function automatic int gpos(input logic a, input logic b);
    return (a && !b) ? 1 : (a && b) ? 2 : (!a && b) ? 3 : 0;
  endfunction

  // monitor: pops expected strobes and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (cnt_up_o && cnt_dn_o) chk(1'b0, "R11", "both strobes high", 1, 0);
      else if (cnt_up_o || cnt_dn_o) begin
        if (index_hit_o) hit_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected strobe up", int'(cnt_up_o), -1);
        else begin
          automatic bit e = exp_q.pop_front();
          chk(cnt_up_o == e, "R2", "strobe direction up", int'(cnt_up_o), int'(e));
        end
      end
    end
  end

  // driver: predicts from the requirements, pushes, then drives
  task automatic step(input logic na, input logic nb, input string req);
    bit hit = 1'b0;
    bit up  = 1'b0;
    logic pa = phase_a_i;
    logic pb = phase_b_i;
    if (quad_mode_i) begin
      int d = (gpos(na, nb) - gpos(pa, pb) + 4) % 4;
      if (d == 1 || d == 3) begin
        up = (d == 1);
        case (res_sel_i)
          2'd0:    hit = (pa != na) && !pb && !nb;
          2'd1:    hit = (pa != na);
          default: hit = 1'b1;
        endcase
      end
    end else begin
      hit = !pa && na;
      up  = nb;
    end
    if (hit) exp_q.push_back(up);
    @(negedge clk);
    phase_a_i = na;
    phase_b_i = nb;
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, req, "pending strobes after step", exp_q.size(), 0);
    if (hit) chk(dir_o == up, "R8", "dir after strobe", int'(dir_o), int'(up));
  endtask

  task automatic fwd_cycle(input string req);
    step(1, 0, req); step(1, 1, req); step(0, 1, req); step(0, 0, req);
  endtask
  task automatic rev_cycle(input string req);
    step(0, 1, req); step(1, 1, req); step(1, 0, req); step(0, 0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_up_o == 0, "R1", "cnt_up_o", int'(cnt_up_o), 0);
    chk(cnt_dn_o == 0, "R1", "cnt_dn_o", int'(cnt_dn_o), 0);
    chk(dir_o == 1, "R1", "dir_o", int'(dir_o), 1);
    chk(noise_err_o == 0, "R1", "noise_err_o", int'(noise_err_o), 0);
    chk(index_hit_o == 0, "R1", "index_hit_o", int'(index_hit_o), 0);

    // R2 x4 forward and reverse
    fwd_cycle("R2");
    rev_cycle("R2");
    // R3 x2 and x1 and code 3
    res_sel_i = 2'd1;
    fwd_cycle("R3");
    rev_cycle("R3");
    res_sel_i = 2'd0;
    fwd_cycle("R3");
    rev_cycle("R3");
    res_sel_i = 2'd3;
    step(1, 0, "R3");
    step(0, 0, "R3");
    res_sel_i = 2'd2;

    // R4 short glitch rejected (monitor flags any strobe)
    @(negedge clk); phase_a_i = 1'b1;
    repeat (2) @(negedge clk); phase_a_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "queue after glitch", exp_q.size(), 0);
    chk(dir_o == 0, "R4", "dir unchanged by glitch", int'(dir_o), 0);

    // R5 illegal transition
    step(1, 1, "R5");
    chk(noise_err_o == 1, "R5", "noise after illegal step", int'(noise_err_o), 1);
    repeat (20) @(negedge clk);
    chk(noise_err_o == 1, "R6", "noise sticky", int'(noise_err_o), 1);
    err_clr_i = 1'b1; @(negedge clk); err_clr_i = 1'b0;
    chk(noise_err_o == 0, "R6", "noise cleared", int'(noise_err_o), 0);
    step(0, 0, "R5");
    chk(noise_err_o == 1, "R5", "noise on second illegal step", int'(noise_err_o), 1);
    err_clr_i = 1'b1; @(negedge clk); err_clr_i = 1'b0;

    // R7 clock/direction mode
    quad_mode_i = 1'b0;
    res_sel_i = 2'd0;
    step(0, 1, "R7");
    step(1, 1, "R7");
    step(0, 1, "R7");
    step(1, 0, "R7");
    step(0, 0, "R7");
    @(negedge clk); phase_b_i = 1'b1; exp_q.push_back(1'b1);
    repeat (3) @(negedge clk); phase_a_i = 1'b1;
    repeat (2) @(negedge clk); phase_a_i = 1'b0;
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "short pulse counted", exp_q.size(), 0);
    chk(dir_o == 1, "R8", "dir after short pulse", int'(dir_o), 1);
    step(1, 0, "R7");
    chk(noise_err_o == 0, "R6", "noise in clock/dir mode", int'(noise_err_o), 0);
    step(0, 0, "R7");

    // R9 direct index
    quad_mode_i = 1'b1;
    res_sel_i = 2'd2;
    repeat (12) @(negedge clk);
    index_i = 1'b0; repeat (4) @(negedge clk);
    chk(index_hit_o == 1, "R9", "direct index active low", int'(index_hit_o), 1);
    idx_pol_i = 1'b1; @(negedge clk);
    chk(index_hit_o == 1, "R9", "polarity ignored", int'(index_hit_o), 1);
    index_i = 1'b1; repeat (4) @(negedge clk);
    chk(index_hit_o == 0, "R9", "direct index idle", int'(index_hit_o), 0);

    // R10 synchronous index
    sync_idx_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(index_hit_o == 0, "R10", "sync index idle between strobes", int'(index_hit_o), 0);
    hit_cnt = 0;
    fwd_cycle("R10");
    chk(hit_cnt == 4, "R10", "sync hits at matching level", hit_cnt, 4);
    index_i = 1'b0;
    repeat (4) @(negedge clk);
    hit_cnt = 0;
    rev_cycle("R10");
    chk(hit_cnt == 0, "R10", "sync hits at other level", hit_cnt, 0);
    quad_mode_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(index_hit_o == 1, "R10", "forced direct in clock/dir mode", int'(index_hit_o), 1);

    summary();
    $finish;
  end
endmodule